// File: doc/BRIEF.md
# Two-Output Prioritised Interrupt Controller

This block gathers a set of interrupt request lines and presents them to a processor on two outputs: a normal interrupt and a fast interrupt. Each source line first passes through a per-source polarity stage and a per-source capture mode, level or latched. The conditioned lines are then shared by two independent banks. Each bank has its own enable mask, its own latched state, its own priority threshold and its own output pin.

Software reaches every register over a simple synchronous bus with address, write data, read data, and one-cycle read and write strobes. Read data is combinational and valid in the cycle the read strobe is high. Reading a bank's acknowledge register has a side effect: it clears that bank's latched pending bits. A handler reads the bank's status register, then its current-source register, services that source, and repeats until status reads zero.

Each source carries a 4-bit priority, where 0 is the most urgent. The current-source register names the pending source with the smallest priority value. When several sources share that value, it names the lowest-numbered one.

Top module: `intc_dual`

## Requirements
- R1: After synchronous reset, both outputs are low and every enable bit, threshold, polarity bit, sticky bit and priority field reads zero.
- R2: The polarity register at 0x200 selects per source: a 1 bit passes the request line unchanged, and a 0 bit inverts it.
- R3: In a bank (base 0x000 for the normal output, 0x100 for the fast output), writing ones to offset 0x08 sets the matching enable bits. Writing ones to offset 0x0C clears them. Offset 0x08 reads back the enable mask.
- R4: Raw status at bank offset 0x04 shows the conditioned requests after polarity and capture mode, before the enable mask.
- R5: Status at bank offset 0x00 reads the sources that are pending, enabled in that bank, and have a priority value not above the bank threshold.
- R6: Current source at bank offset 0x20 reads the index of the status source with the smallest priority value, using the lowest index on a tie. It reads 0 when status is zero.
- R7: The threshold at bank offset 0x2C holds 4 bits. A source passes when its priority is less than or equal to the threshold, so 0xF admits every source.
- R8: The sticky register at 0x204 selects the capture mode. A 1 bit latches a conditioned 1, which stays pending after the line drops until that bank's acknowledge register (offset 0x28) is read. A 0 bit follows the line with no latching.
- R9: An acknowledge read clears only the latched state of its own bank.
- R10: Source n's priority lives in the low 4 bits of the word at 0x300 + 4*n. It reads back with the upper bits zero.
- R11: Each output is registered. It is high one cycle after its bank's status becomes nonzero and low one cycle after status becomes zero.
- R12: The two banks are independent: enables and thresholds written in one bank do not change the other bank's status, current source or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; side effects occur at the clock edge |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 32 | Interrupt request lines, already synchronous to clk |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Three request patterns are applied. Inverted idle lines under reset polarity separate the inversion path from pass-through. Three sources with mixed priorities, two of them tied, separate the priority selection from the tie-break by index. Threshold values 0, 1 and 15 show that filtering acts on status and on the current source rather than on raw status. A latched source whose line then drops, followed by acknowledge reads in one bank and then the other, separates level capture from sticky capture and shows that clearing stays inside one bank. The output pins are sampled in the cycle a threshold change lands and again one cycle later, which confirms the single register stage.

// File: rtl/intc_pkg.sv
// Package: shared sizes, register offsets and the per-bank command type.
// Assumes a 12-bit byte address space and word-aligned accesses.
package intc_pkg;
    localparam int NSRC_DEF = 32;
    localparam int PRIO_W_DEF = 4;

    // Offsets inside a bank page; a bank page is 0x100 bytes.
    localparam logic [7:0] OFF_STAT = 8'h00;
    localparam logic [7:0] OFF_RAW  = 8'h04;
    localparam logic [7:0] OFF_EN   = 8'h08;
    localparam logic [7:0] OFF_DIS  = 8'h0C;
    localparam logic [7:0] OFF_CUR  = 8'h20;
    localparam logic [7:0] OFF_ACK  = 8'h28;
    localparam logic [7:0] OFF_THR  = 8'h2C;

    // Shared configuration addresses.
    localparam logic [11:0] ADDR_POL    = 12'h200;
    localparam logic [11:0] ADDR_STICKY = 12'h204;
    localparam logic [3:0]  PRIO_PAGE   = 4'h3;

    // Strobes decoded for one bank.
    typedef struct packed {
        logic wr_en;
        logic wr_dis;
        logic wr_thr;
        logic rd_ack;
    } bank_cmd_t;
endpackage

// File: rtl/intc_cfg.sv
// Shared configuration: polarity, capture mode and per-source priority.
// Produces the conditioned request vector used by both banks.
// Assumes src_in is already synchronous to clk.
module intc_cfg
    import intc_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int PRIO_W = PRIO_W_DEF,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_pol,
    input  logic                     wr_sticky,
    input  logic                     wr_prio,
    input  logic [IDX_W-1:0]         prio_idx,
    input  logic [NSRC-1:0]          wdata,
    input  logic [NSRC-1:0]          src_in,
    output logic [NSRC-1:0]          pol,
    output logic [NSRC-1:0]          sticky,
    output logic [NSRC*PRIO_W-1:0]   prio_flat,
    output logic [NSRC-1:0]          cond
);
    // Polarity and sticky select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol    <= '0;
            sticky <= '0;
        end else begin
            if (wr_pol)    pol    <= wdata;
            if (wr_sticky) sticky <= wdata;
        end
    end

    // One priority field per source.
    for (genvar i = 0; i < NSRC; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_flat[i*PRIO_W +: PRIO_W] <= '0;
            else if (wr_prio && prio_idx == IDX_W'(i))
                prio_flat[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
        end
    end

    // Polarity stage: a 1 select passes the line, a 0 select inverts it.
    assign cond = ~(src_in ^ pol);
endmodule

// File: rtl/intc_arbiter.sv
// Arbiter: picks the qualified source with the smallest priority value.
// A tie goes to the lowest index. Reports index 0 when nothing qualifies.
module intc_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        qual,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic [IDX_W-1:0]       cur
);
    logic [PRIO_W-1:0] best_p;
    logic              found;

    // Linear scan; a strict compare keeps the lower index on a tie.
    always_comb begin
        best_p = '1;
        cur    = '0;
        found  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (qual[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
                best_p = prio_flat[i*PRIO_W +: PRIO_W];
                cur    = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end

    // No qualified source may beat the chosen one (R6).
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                if (qual[i])
                    assert_best_prio_R6: assert (prio_flat[i*PRIO_W +: PRIO_W] >= prio_flat[cur*PRIO_W +: PRIO_W])
                        else $error("R6: source %0d beats selected %0d", i, cur);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
// One output bank: enable mask, latched pending bits, threshold, status,
// current-source arbitration and the registered output pin.
// Assumes that at most one command strobe is high per cycle.
module intc_bank
    import intc_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int PRIO_W = PRIO_W_DEF,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bank_cmd_t              cmd,
    input  logic [NSRC-1:0]        wdata,
    input  logic [NSRC-1:0]        cond,
    input  logic [NSRC-1:0]        sticky,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic [NSRC-1:0]        raw,
    output logic [NSRC-1:0]        status,
    output logic [NSRC-1:0]        en,
    output logic [IDX_W-1:0]       cur,
    output logic [PRIO_W-1:0]      thr,
    output logic                   out
);
    logic [NSRC-1:0] latch_q;
    logic [NSRC-1:0] pass;

    // Enable mask: set and clear through separate write registers.
    always_ff @(posedge clk) begin
        if (!rst_n)          en <= '0;
        else if (cmd.wr_en)  en <= en | wdata;
        else if (cmd.wr_dis) en <= en & ~wdata;
    end

    // Priority threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)          thr <= '0;
        else if (cmd.wr_thr) thr <= wdata[PRIO_W-1:0];
    end

    // Latched pending bits: the acknowledge read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (cmd.rd_ack) latch_q <= '0;
        else                 latch_q <= latch_q | (sticky & cond);
    end

    // Threshold filter per source.
    for (genvar i = 0; i < NSRC; i++) begin : g_pass
        assign pass[i] = prio_flat[i*PRIO_W +: PRIO_W] <= thr;
    end

    assign raw    = cond | (sticky & latch_q);
    assign status = raw & en & pass;

    intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (status),
        .prio_flat (prio_flat),
        .cur       (cur)
    );

    // Registered output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else        out <= |status;
    end

    assert_out_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out == $past(|status))
        else $error("R11: output does not follow status by one cycle");

    assert_cur_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |-> status[cur])
        else $error("R6: current source is not pending");

    assert_cur_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> cur == '0)
        else $error("R6: current source nonzero with empty status");

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.wr_en |=> (en & $past(wdata)) == $past(wdata))
        else $error("R3: enable write lost bits");

    assert_disable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.wr_dis |=> (en & $past(wdata)) == '0)
        else $error("R3: disable write left bits set");

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rd_ack |=> (raw & ~cond) == '0)
        else $error("R8: latched state survived acknowledge");
endmodule

// File: rtl/intc_dual.sv
// Top: address decode, shared configuration, two output banks, read mux.
// Bank pages sit at 0x000 and 0x100; shared registers at 0x200 and up.
// Assumes NSRC <= 32 so the priority words fit in one 0x80-byte window.
module intc_dual
    import intc_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int PRIO_W = PRIO_W_DEF,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int NBANK  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_o,
    output logic            fiq_o
);
    logic                   in_bank;
    logic                   bank_idx;
    logic [7:0]             off;
    logic                   in_prio;
    logic [IDX_W-1:0]       prio_idx;
    logic [NSRC-1:0]        pol, sticky, cond;
    logic [NSRC*PRIO_W-1:0] prio_flat;

    bank_cmd_t              cmd    [NBANK];
    logic [NSRC-1:0]        raw    [NBANK];
    logic [NSRC-1:0]        status [NBANK];
    logic [NSRC-1:0]        en     [NBANK];
    logic [IDX_W-1:0]       cur    [NBANK];
    logic [PRIO_W-1:0]      thr    [NBANK];
    logic [NBANK-1:0]       outs;

    assign in_bank  = bus_addr[11:9] == 3'b000;
    assign bank_idx = bus_addr[8];
    assign off      = bus_addr[7:0];
    assign in_prio  = bus_addr[11:8] == PRIO_PAGE && bus_addr[7:IDX_W+2] == '0;
    assign prio_idx = bus_addr[IDX_W+1:2];

    intc_cfg #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pol    (bus_wr && bus_addr == ADDR_POL),
        .wr_sticky (bus_wr && bus_addr == ADDR_STICKY),
        .wr_prio   (bus_wr && in_prio),
        .prio_idx  (prio_idx),
        .wdata     (bus_wdata),
        .src_in    (src_in),
        .pol       (pol),
        .sticky    (sticky),
        .prio_flat (prio_flat),
        .cond      (cond)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = in_bank && bank_idx == 1'(b);
        assign cmd[b].wr_en  = bus_wr && hit && off == OFF_EN;
        assign cmd[b].wr_dis = bus_wr && hit && off == OFF_DIS;
        assign cmd[b].wr_thr = bus_wr && hit && off == OFF_THR;
        assign cmd[b].rd_ack = bus_rd && hit && off == OFF_ACK;

        intc_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[b]),
            .wdata     (bus_wdata),
            .cond      (cond),
            .sticky    (sticky),
            .prio_flat (prio_flat),
            .raw       (raw[b]),
            .status    (status[b]),
            .en        (en[b]),
            .cur       (cur[b]),
            .thr       (thr[b]),
            .out       (outs[b])
        );
    end

    assign irq_o = outs[0];
    assign fiq_o = outs[1];

    // Read mux; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (in_bank) begin
            case (off)
                OFF_STAT: bus_rdata = status[bank_idx];
                OFF_RAW:  bus_rdata = raw[bank_idx];
                OFF_EN:   bus_rdata = en[bank_idx];
                OFF_CUR:  bus_rdata = NSRC'(cur[bank_idx]);
                OFF_THR:  bus_rdata = NSRC'(thr[bank_idx]);
                default:  bus_rdata = '0;
            endcase
        end else if (bus_addr == ADDR_POL) begin
            bus_rdata = pol;
        end else if (bus_addr == ADDR_STICKY) begin
            bus_rdata = sticky;
        end else if (in_prio) begin
            bus_rdata = NSRC'(prio_flat[prio_idx*PRIO_W +: PRIO_W]);
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd))
        else $error("R3: read and write strobes together");
endmodule

// File: tb/intc_dual_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: the read task queues the expected value, and a monitor
// compares it against bus_rdata mid-cycle. Pin checks are made directly.
module intc_dual_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    intc_dual u_intc_dual (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    // Monitor: pops one expected item for every read strobe.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr %h: got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        #1;
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        pin(irq_o, 1'b0, "R1 irq after reset");
        pin(fiq_o, 1'b0, "R1 fiq after reset");
        rd(12'h008, 32'h0, "R1 enable");
        rd(12'h200, 32'h0, "R1 polarity");
        rd(12'h204, 32'h0, "R1 sticky");
        rd(12'h02C, 32'h0, "R1 threshold");
        rd(12'h37C, 32'h0, "R1 priority");
        // R2 inversion with reset polarity, then pass-through
        rd(12'h004, 32'hFFFF_FFFF, "R2 inverted idle lines");
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h004, 32'h0, "R2 pass-through");
        // R10 priorities
        wr(12'h314, 32'h3);
        wr(12'h324, 32'h1);
        wr(12'h330, 32'h1);
        wr(12'h350, 32'hFF);
        rd(12'h324, 32'h1, "R10 priority src9");
        rd(12'h314, 32'h3, "R10 priority src5");
        rd(12'h350, 32'hF, "R10 priority width");
        wr(12'h02C, 32'hF);
        // R4 raw before mask, R3 enable
        src_in = 32'h0000_1220;
        rd(12'h004, 32'h0000_1220, "R4 raw");
        rd(12'h000, 32'h0, "R3 nothing enabled");
        wr(12'h008, 32'h0000_1220);
        rd(12'h008, 32'h0000_1220, "R3 enable readback");
        rd(12'h000, 32'h0000_1220, "R5 status");
        rd(12'h020, 32'd9, "R6 tie to lowest index");
        pin(irq_o, 1'b1, "R11 irq high");
        pin(fiq_o, 1'b0, "R12 fiq untouched");
        // R7 threshold
        wr(12'h02C, 32'h0);
        pin(irq_o, 1'b1, "R11 irq one cycle lag");
        @(negedge clk);
        pin(irq_o, 1'b0, "R11 irq dropped");
        rd(12'h000, 32'h0, "R7 threshold 0 blocks all");
        rd(12'h020, 32'd0, "R6 idle current");
        wr(12'h02C, 32'h1);
        rd(12'h02C, 32'h1, "R7 threshold readback");
        rd(12'h000, 32'h0000_1200, "R7 threshold 1");
        rd(12'h020, 32'd9, "R6 current at threshold 1");
        wr(12'h00C, 32'h0000_0200);
        rd(12'h008, 32'h0000_1020, "R3 disable");
        rd(12'h000, 32'h0000_1000, "R3 status after disable");
        rd(12'h020, 32'd12, "R6 next source");
        wr(12'h02C, 32'hF);
        rd(12'h020, 32'd12, "R6 best priority over index");
        // R12 fast bank
        wr(12'h108, 32'h0000_0020);
        wr(12'h12C, 32'hF);
        rd(12'h100, 32'h0000_0020, "R12 fast status");
        rd(12'h120, 32'd5, "R12 fast current");
        rd(12'h008, 32'h0000_1020, "R12 normal enable unchanged");
        pin(fiq_o, 1'b1, "R12 fiq high");
        // R8 and R9 sticky capture and per-bank acknowledge
        wr(12'h204, 32'h0000_0200);
        wr(12'h008, 32'h0000_0200);
        @(negedge clk);
        src_in = 32'h0;
        rd(12'h004, 32'h0000_0200, "R8 latched after drop, level gone");
        rd(12'h020, 32'd9, "R8 latched source current");
        rd(12'h104, 32'h0000_0200, "R8 fast bank latched");
        rd(12'h100, 32'h0, "R12 fast status masked");
        rd(12'h028, 32'h0, "R8 acknowledge read");
        rd(12'h004, 32'h0, "R8 cleared by acknowledge");
        rd(12'h104, 32'h0000_0200, "R9 other bank kept");
        rd(12'h128, 32'h0, "R9 fast acknowledge");
        rd(12'h104, 32'h0, "R9 fast cleared");
        pin(irq_o, 1'b0, "R11 irq low at end");
        pin(fiq_o, 1'b0, "R11 fiq low at end");
        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            fails++; checks++;
            $display("FAIL scoreboard: got %0d left expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule